// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps calendar time as packed BCD bytes: seconds, minutes, hours, day of month, month (1-based), a two-digit year and a weekday. A synchronous single-cycle `tick` pulse advances the clock by one second while the run bit is set. When the run bit is clear the counters are frozen, so software can rewrite the fields one at a time without a carry corrupting them. Rollover accounts for month lengths and leap years across years 00 to 99. A year counts as leap when its value is divisible by 4.

A six-field alarm covers seconds through year and has no weekday field. It sets a sticky flag on the tick that makes the time equal to it. The interrupt output is that flag gated by an enable bit. Software clears the flag by writing one to its bit. The readable status byte is a snapshot taken at each status read, so the first read after an event returns the previous value and the next read shows the current one. All registers are reached through a byte-wide port with a combinational read path.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset, day of month and month read 8'h01, and every other time field, every alarm field, control, interrupt enable and status read 8'h00.
- R2: Register map (5-bit address): time fields at 0x00..0x06 in the order seconds, minutes, hours, day, month, year, weekday. Alarm fields are at 0x08..0x0D in the order seconds, minutes, hours, day, month, year. Control is at 0x10 with the run bit at bit 0, interrupt enable is at 0x11 with the alarm enable at bit 3, and status is at 0x12 with the alarm flag at bit 6. A written time or alarm byte reads back unchanged.
- R3: When the run bit is 0, a tick leaves every time field unchanged. When the run bit is 1, a tick advances seconds by one BCD step at the same clock edge.
- R4: Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 and carry into day of month and weekday.
- R5: Day of month wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02.
- R6: In month 02, day wraps after 29 when the year value is divisible by 4 (including 00) and after 28 otherwise.
- R7: Month wraps from 12 to 01 and increments the year, and the year wraps from 99 to 00.
- R8: Weekday counts 00 to 06 and returns to 00 after 06 at each day rollover.
- R9: A write to any time register in the same cycle as a tick wins: the written value is stored and the tick is dropped. A written value never carries into a higher field.
- R10: The alarm flag is set two clock edges after the tick that makes seconds through year equal to the alarm fields. Weekday is not compared. `alarm_irq` is high exactly when the flag is set and the enable bit is 1.
- R11: Writing status with bit 6 = 1 clears the flag, and writing it with bit 6 = 0 leaves the flag unchanged.
- R12: A status read returns the flag value captured at the previous status read, and then captures the current flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (updates the status snapshot) |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| alarm_irq | output | 1 | Active-high alarm interrupt |

## Verification
The clock is preloaded at the last second before each kind of rollover: a plain minute, the end of a day with the weekday at 06, 30-day and 31-day months, February in leap and common years (including year 00), and the end of the century. Each preload isolates one limit in the carry chain. Ticks with the run bit clear, and ticks that coincide with a time write, show whether freeze and write priority hold or a stray advance slips through. Alarm runs with the enable on and off, W1C writes with bit 6 set and clear, and back-to-back status reads separate the live flag, the gated output and the read snapshot.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int BYTE_W    = 8;
   localparam int NUM_TIME  = 7;
   localparam int NUM_ALARM = 6;

   localparam int IDX_SEC  = 0;
   localparam int IDX_MIN  = 1;
   localparam int IDX_HOUR = 2;
   localparam int IDX_DAY  = 3;
   localparam int IDX_MON  = 4;
   localparam int IDX_YEAR = 5;
   localparam int IDX_WDAY = 6;

   // Next packed-BCD value without any limit applied.
   function automatic logic [7:0] bcd_step(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
      return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
   endfunction

   function automatic logic year_is_leap(input logic [7:0] yr);
      return bcd_to_bin(yr) % 8'd4 == 8'd0;
   endfunction

   // Last valid day (BCD) of a month for a given year.
   function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   // Static top value of each time field.
   function automatic logic [7:0] field_top(input int idx);
      case (idx)
         IDX_SEC, IDX_MIN: return 8'h59;
         IDX_HOUR:         return 8'h23;
         IDX_DAY:          return 8'h31;
         IDX_MON:          return 8'h12;
         IDX_YEAR:         return 8'h99;
         default:          return 8'h06;
      endcase
   endfunction

   // Reset and wrap value of each time field.
   function automatic logic [7:0] field_base(input int idx);
      return (idx == IDX_DAY || idx == IDX_MON) ? 8'h01 : 8'h00;
   endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
   parameter int          W        = 8,
   parameter logic [7:0]  BASE_VAL = 8'h00
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic [W-1:0] top,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] value,
   output logic         carry
);
   import rtc_cal_pkg::*;

   if (W != 8) begin : g_bad_width
      $error("rtc_bcd_field supports only byte-wide packed BCD");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            value <= BASE_VAL;
      else if (wr_en)        value <= wr_data;
      else if (inc) begin
         if (value == top)   value <= BASE_VAL;
         else                value <= bcd_step(value);
      end
   end

   assign carry = inc && (value == top);

   AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      inc && !wr_en && value == top |=> value == BASE_VAL); // R4
   AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !inc && !wr_en |=> $stable(value)); // R3

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
   import rtc_cal_pkg::*;
#(
   parameter int NF = NUM_TIME
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv,
   input  logic [NF-1:0]        wr_en,
   input  logic [BYTE_W-1:0]    wr_data,
   output logic [NF-1:0][7:0]   fields,
   output logic                 adv_done
);

   if (NF != NUM_TIME) begin : g_bad_nf
      $error("rtc_time_core needs exactly seven time fields");
   end

   logic [NF-1:0] inc;
   logic [NF-1:0] carry;

   for (genvar i = 0; i < NF; i++) begin : g_fld
      logic [7:0] top;
      if (i == IDX_DAY) begin : g_dyn
         assign top = last_day(fields[IDX_MON], fields[IDX_YEAR]);
      end else begin : g_fix
         assign top = field_top(i);
      end

      if (i == IDX_SEC) begin : g_src_tick
         assign inc[i] = adv;
      end else if (i == IDX_WDAY) begin : g_src_day
         assign inc[i] = carry[IDX_HOUR];
      end else begin : g_src_chain
         assign inc[i] = carry[i-1];
      end

      rtc_bcd_field #(.W(BYTE_W), .BASE_VAL(field_base(i))) u_fld (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc     (inc[i]),
         .top     (top),
         .wr_en   (wr_en[i]),
         .wr_data (wr_data),
         .value   (fields[i]),
         .carry   (carry[i])
      );
   end

   logic unused_carry;
   assign unused_carry = carry[IDX_YEAR] ^ carry[IDX_WDAY];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) adv_done <= 1'b0;
      else        adv_done <= adv;
   end

   AST_WDAY_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      inc[IDX_WDAY] && !wr_en[IDX_WDAY] |=> fields[IDX_WDAY] != $past(fields[IDX_WDAY])); // R8
   AST_DAY_WITH_WDAY: assert property (@(posedge clk) disable iff (!rst_n)
      inc[IDX_DAY] |-> inc[IDX_WDAY]); // R4

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
   import rtc_cal_pkg::*;
#(
   parameter int NA = NUM_ALARM
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NA-1:0][7:0]  now_i,
   input  logic                adv_done,
   input  logic [NA-1:0]       wr_en,
   input  logic [BYTE_W-1:0]   wr_data,
   input  logic                clr_req,
   input  logic                snap_req,
   output logic [NA-1:0][7:0]  alarm_q,
   output logic                flag,
   output logic                snap
);

   logic [NA-1:0] eq;
   logic          match;

   for (genvar i = 0; i < NA; i++) begin : g_alm
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        alarm_q[i] <= 8'h00;
         else if (wr_en[i]) alarm_q[i] <= wr_data;
      end
      assign eq[i] = (alarm_q[i] == now_i[i]);
   end

   assign match = &eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flag <= 1'b0;
      else if (adv_done && match) flag <= 1'b1;
      else if (clr_req)           flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        snap <= 1'b0;
      else if (snap_req) snap <= flag;
   end

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req && !(adv_done && match) |=> !flag); // R11
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clr_req |=> flag); // R10
   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_req |=> $stable(snap)); // R12

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
   import rtc_cal_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 8,
   parameter int TIME_BASE  = 0,
   parameter int ALARM_BASE = 8,
   parameter int CTRL_ADDR  = 16,
   parameter int IEN_ADDR   = 17,
   parameter int STAT_ADDR  = 18,
   parameter int RUN_BIT    = 0,
   parameter int AIE_BIT    = 3,
   parameter int AF_BIT     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              alarm_irq
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (DATA_W != BYTE_W) begin : g_bad_data
      $error("register port must be byte wide");
   end
   if (TIME_BASE + NUM_TIME > ADDR_SPAN || ALARM_BASE + NUM_ALARM > ADDR_SPAN ||
       CTRL_ADDR >= ADDR_SPAN || IEN_ADDR >= ADDR_SPAN || STAT_ADDR >= ADDR_SPAN) begin : g_bad_map
      $error("register map does not fit the address width");
   end
   if (RUN_BIT >= DATA_W || AIE_BIT >= DATA_W || AF_BIT >= DATA_W) begin : g_bad_bits
      $error("control bit position outside the data byte");
   end

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

   logic [NUM_TIME-1:0]       time_wr;
   logic [NUM_ALARM-1:0]      alarm_wr;
   logic [NUM_TIME-1:0][7:0]  fields;
   logic [NUM_ALARM-1:0][7:0] alarm_q;
   logic                      run_q;
   logic                      aie_q;
   logic                      adv;
   logic                      adv_done;
   logic                      flag;
   logic                      snap;
   logic                      clr_req;
   logic                      snap_req;

   for (genvar i = 0; i < NUM_TIME; i++) begin : g_twr
      assign time_wr[i] = reg_wr && (reg_addr == ADDR_W'(TIME_BASE + i));
   end
   for (genvar i = 0; i < NUM_ALARM; i++) begin : g_awr
      assign alarm_wr[i] = reg_wr && (reg_addr == ADDR_W'(ALARM_BASE + i));
   end

   // A time write in the same cycle suppresses the tick completely.
   assign adv      = tick && run_q && !(|time_wr);
   assign clr_req  = reg_wr && (reg_addr == A_STAT) && reg_wdata[AF_BIT];
   assign snap_req = reg_rd && (reg_addr == A_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         aie_q <= 1'b0;
      end else if (reg_wr) begin
         if (reg_addr == A_CTRL) run_q <= reg_wdata[RUN_BIT];
         if (reg_addr == A_IEN)  aie_q <= reg_wdata[AIE_BIT];
      end
   end

   rtc_time_core #(.NF(NUM_TIME)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .wr_en    (time_wr),
      .wr_data  (reg_wdata),
      .fields   (fields),
      .adv_done (adv_done)
   );

   rtc_alarm_unit #(.NA(NUM_ALARM)) u_alarm (
      .clk      (clk),
      .rst_n    (rst_n),
      .now_i    (fields[NUM_ALARM-1:0]),
      .adv_done (adv_done),
      .wr_en    (alarm_wr),
      .wr_data  (reg_wdata),
      .clr_req  (clr_req),
      .snap_req (snap_req),
      .alarm_q  (alarm_q),
      .flag     (flag),
      .snap     (snap)
   );

   assign alarm_irq = flag && aie_q;

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_TIME; i++)
         if (reg_addr == ADDR_W'(TIME_BASE + i)) reg_rdata = fields[i];
      for (int i = 0; i < NUM_ALARM; i++)
         if (reg_addr == ADDR_W'(ALARM_BASE + i)) reg_rdata = alarm_q[i];
      if (reg_addr == A_CTRL) reg_rdata[RUN_BIT] = run_q;
      if (reg_addr == A_IEN)  reg_rdata[AIE_BIT] = aie_q;
      if (reg_addr == A_STAT) reg_rdata[AF_BIT]  = snap;
   end

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      time_wr[IDX_SEC] |=> fields[IDX_SEC] == $past(reg_wdata)); // R9
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q && !reg_wr |=> $stable(fields)); // R3
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_irq) |-> $past(adv_done) || $past(reg_wr)); // R10

endmodule

// File: tb/bcd_calendar_rtc_tb_top.sv
module bcd_calendar_rtc_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [4:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       alarm_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bcd_calendar_rtc dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .alarm_irq (alarm_irq)
   );

   localparam logic [4:0] A_SEC = 5'h00, A_MIN = 5'h01, A_HR = 5'h02, A_DAY = 5'h03,
                          A_MON = 5'h04, A_YR = 5'h05, A_WD = 5'h06, A_ALM = 5'h08,
                          A_CTRL = 5'h10, A_IEN = 5'h11, A_STAT = 5'h12;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] s, mi, h, d, mo, y, wd);
      wr(A_CTRL, 8'h00);
      wr(A_SEC, s); wr(A_MIN, mi); wr(A_HR, h); wr(A_DAY, d);
      wr(A_MON, mo); wr(A_YR, y); wr(A_WD, wd);
      wr(A_CTRL, 8'h01);
   endtask

   task automatic expect_time(input string tag, input logic [7:0] s, mi, h, d, mo, y, wd);
      logic [7:0] v;
      rd(A_SEC, v); chk({tag, " sec"}, v, s);
      rd(A_MIN, v); chk({tag, " min"}, v, mi);
      rd(A_HR,  v); chk({tag, " hour"}, v, h);
      rd(A_DAY, v); chk({tag, " day"}, v, d);
      rd(A_MON, v); chk({tag, " month"}, v, mo);
      rd(A_YR,  v); chk({tag, " year"}, v, y);
      rd(A_WD,  v); chk({tag, " wday"}, v, wd);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      expect_time("R1 reset", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
      for (int i = 0; i < 6; i++) begin
         rd(A_ALM + 5'(i), v); chk("R1 alarm reset", v, 8'h00);
      end
      rd(A_CTRL, v); chk("R1 ctrl reset", v, 8'h00);
      rd(A_IEN, v);  chk("R1 ien reset", v, 8'h00);
      rd(A_STAT, v); chk("R1 status reset", v, 8'h00);
      chk("R1 irq reset", {7'b0, alarm_irq}, 8'h00);
   endtask

   task automatic t_map();
      logic [7:0] v;
      wr(A_ALM + 5'd2, 8'h17); rd(A_ALM + 5'd2, v); chk("R2 alarm hour readback", v, 8'h17);
      wr(A_IEN, 8'hFF); rd(A_IEN, v); chk("R2 ien bit3 only", v, 8'h08);
      wr(A_IEN, 8'h00);
      wr(A_CTRL, 8'hFF); rd(A_CTRL, v); chk("R2 ctrl bit0 only", v, 8'h01);
      wr(A_CTRL, 8'h00);
   endtask

   task automatic t_run();
      logic [7:0] v;
      set_time(8'h30, 8'h10, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
      wr(A_CTRL, 8'h00);
      pulse_tick();
      rd(A_SEC, v); chk("R3 frozen tick", v, 8'h30);
      wr(A_CTRL, 8'h01);
      pulse_tick();
      rd(A_SEC, v); chk("R3 running tick", v, 8'h31);
      set_time(8'h59, 8'h10, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
      pulse_tick();
      rd(A_SEC, v); chk("R4 sec wrap", v, 8'h00);
      rd(A_MIN, v); chk("R4 min carry", v, 8'h11);
   endtask

   task automatic t_day_end();
      set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h03, 8'h21, 8'h06);
      pulse_tick();
      expect_time("R4 R8 day end", 8'h00, 8'h00, 8'h00, 8'h06, 8'h03, 8'h21, 8'h00);
      set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h21, 8'h02);
      pulse_tick();
      expect_time("R5 30-day month", 8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h21, 8'h03);
      set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h21, 8'h02);
      pulse_tick();
      expect_time("R5 31-day month", 8'h00, 8'h00, 8'h00, 8'h31, 8'h01, 8'h21, 8'h03);
   endtask

   task automatic t_feb();
      set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h01);
      pulse_tick();
      expect_time("R6 common feb", 8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h23, 8'h02);
      set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h01);
      pulse_tick();
      expect_time("R6 leap feb", 8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24, 8'h02);
      set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h00, 8'h01);
      pulse_tick();
      expect_time("R6 year00 feb", 8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h00, 8'h02);
   endtask

   task automatic t_century();
      set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h05);
      pulse_tick();
      expect_time("R7 century", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h06);
   endtask

   task automatic t_write_prio();
      logic [7:0] v;
      set_time(8'h30, 8'h10, 8'h04, 8'h02, 8'h02, 8'h02, 8'h02);
      @(negedge clk);
      tick = 1'b1; reg_wr = 1'b1; reg_addr = A_SEC; reg_wdata = 8'h42;
      @(negedge clk);
      tick = 1'b0; reg_wr = 1'b0;
      rd(A_SEC, v); chk("R9 written sec wins", v, 8'h42);
      @(negedge clk);
      tick = 1'b1; reg_wr = 1'b1; reg_addr = A_MIN; reg_wdata = 8'h20;
      @(negedge clk);
      tick = 1'b0; reg_wr = 1'b0;
      rd(A_SEC, v); chk("R9 tick dropped", v, 8'h42);
      rd(A_MIN, v); chk("R9 written min", v, 8'h20);
      wr(A_SEC, 8'h59);
      rd(A_MIN, v); chk("R9 no carry from write", v, 8'h20);
   endtask

   task automatic t_alarm();
      logic [7:0] v;
      set_time(8'h30, 8'h20, 8'h10, 8'h15, 8'h06, 8'h24, 8'h03);
      wr(A_ALM + 5'd0, 8'h31); wr(A_ALM + 5'd1, 8'h20); wr(A_ALM + 5'd2, 8'h10);
      wr(A_ALM + 5'd3, 8'h15); wr(A_ALM + 5'd4, 8'h06); wr(A_ALM + 5'd5, 8'h24);
      wr(A_STAT, 8'h40);
      wr(A_IEN, 8'h08);
      chk("R10 irq before match", {7'b0, alarm_irq}, 8'h00);
      pulse_tick();
      @(negedge clk); @(negedge clk);
      chk("R10 irq on match", {7'b0, alarm_irq}, 8'h01);
      wr(A_STAT, 8'hBF);
      chk("R11 write zero keeps flag", {7'b0, alarm_irq}, 8'h01);
      wr(A_STAT, 8'h40);
      chk("R11 W1C clears", {7'b0, alarm_irq}, 8'h00);
      // Snapshot behaviour with the enable off.
      wr(A_IEN, 8'h00);
      rd(A_STAT, v);
      rd(A_STAT, v); chk("R12 settled clear", v, 8'h00);
      set_time(8'h30, 8'h20, 8'h10, 8'h15, 8'h06, 8'h24, 8'h05);
      pulse_tick();
      @(negedge clk); @(negedge clk);
      chk("R10 gated irq low", {7'b0, alarm_irq}, 8'h00);
      rd(A_STAT, v); chk("R12 first read old", v, 8'h00);
      rd(A_STAT, v); chk("R12 second read new", v, 8'h40);
      wr(A_IEN, 8'h08);
      chk("R10 enable exposes flag", {7'b0, alarm_irq}, 8'h01);
      wr(A_STAT, 8'h40);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map();
      t_run();
      t_day_end();
      t_feb();
      t_century();
      t_write_prio();
      t_alarm();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule